// File: doc/BRIEF.md
# Multiply-Step Unit with Y Register

This block carries out one iteration of a shift-and-add 32-bit multiplication in a single clock cycle. Software drives it once per step. It feeds back the result word as the next partial product and keeps the multiplier in an internal Y register. Each step does four things. It shifts the incoming partial product right by one and puts the exclusive-OR of the held N and V flags into the vacated top bit. It adds the multiplicand only when the low bit of Y is set. It sets new N, Z, V and C flags from that 32-bit addition. It shifts Y right, so that the bit dropped from the partial product enters the top of Y.

The multiplicand is either the low word of a register operand or a sign-extended 13-bit immediate. Y and the flags can be preset through a load port. A load and a step in the same cycle are resolved by the action selector. The selector takes one of three per-cycle actions: HOLD (neither enable is set), LOAD (load enable is set, whatever the step enable is) and STEP (only step enable is set). Every edge makes exactly one of these transitions. HOLD keeps the registers, LOAD writes them from the load port, and STEP writes the step results.

Top module: `mulstep_unit`

## Requirements
- R1: While reset is asserted, Y reads zero and the NZVC flags read 0000.
- R2: With use_imm high, the multiplicand is imm13 (13 bits) sign-extended to 32 bits. Otherwise it is rs2_val[31:0]. rs2_val is then ignored.
- R3: The shifted partial product is {N xor V, rs1_val[31:1]}, taken from the held flags. The flag vector is ordered N=bit3, Z=bit2, V=bit1, C=bit0.
- R4: When y_q[0] is 0, the multiplicand adds zero, so rd_val[31:0] equals the shifted partial product.
- R5: rd_val[31:0] is the 32-bit sum of the shifted partial product and the gated multiplicand. rd_val[63:32] is always zero, and rs1_val[63:32] and rs2_val[63:32] have no effect.
- R6: On a STEP edge, the flags take N = sum bit 31, Z = (sum == 0), V = signed overflow of the 32-bit add, and C = carry out of bit 31.
- R7: On a STEP edge, y_q becomes {rs1_val[0], y_q[31:1]}.
- R8: On a HOLD edge, y_q and nzvc_q keep their values.
- R9: On a LOAD edge, y_q takes load_y and nzvc_q takes load_nzvc. This holds even when step_en is also high.
- R10: Preset Y to an unsigned multiplier and the flags to 0000, then feed rd back as rs1 for 32 steps with a register multiplicand, followed by one step with a zero immediate. The last rd_val[31:0] (high word) concatenated with the following y_q (low word) then equals the signed 32-bit multiplicand times the unsigned 32-bit multiplier, as a 64-bit two's-complement value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Perform a step on this edge |
| load_en | input | 1 | Preset Y and the flags on this edge (wins over step_en) |
| load_y | input | 32 | Value loaded into Y |
| load_nzvc | input | 4 | Flags loaded (N,Z,V,C from bit 3 down) |
| rs1_val | input | 64 | Partial product; low 32 bits used |
| rs2_val | input | 64 | Register multiplicand; low 32 bits used |
| imm13 | input | 13 | Immediate multiplicand, sign-extended |
| use_imm | input | 1 | Select the immediate instead of rs2_val |
| rd_val | output | 64 | Step result; upper 32 bits zero |
| y_q | output | 32 | Current Y register |
| nzvc_q | output | 4 | Current flags, N,Z,V,C from bit 3 down |

## Verification
A load and a step can be requested in the same cycle, and both would write Y and the flags. The bench raises load_en and step_en together, with a partial product whose step result differs from the load values. After that edge it checks that Y and the flags hold the loaded values and not the shifted ones. Gating is also provoked: when Y's low bit is clear, the multiplicand must not affect rd_val. Register and immediate multiplicands are used here, with flag pairs that give both values of N xor V.

// File: rtl/mulstep_pkg.sv
package mulstep_pkg;

    // Action taken on each clock edge by the register stage
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_STEP = 2'd2
    } msu_act_e;

    // Condition flags, packed so that n sits in the top bit
    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } msu_cc_t;

endpackage

// File: rtl/mulstep_opsel.sv
module mulstep_opsel #(
    parameter int WLEN = 32,
    parameter int IMMW = 13
) (
    input  logic [WLEN-1:0] reg_op,
    input  logic [IMMW-1:0] imm,
    input  logic            use_imm,
    output logic [WLEN-1:0] mcand
);
    localparam int EXTW = WLEN - IMMW;

    logic [WLEN-1:0] imm_ext;

    generate
        if (EXTW > 0) begin : g_ext
            assign imm_ext = {{EXTW{imm[IMMW-1]}}, imm};
        end else begin : g_trunc
            assign imm_ext = imm[WLEN-1:0];
        end
    endgenerate

    always_comb begin
        mcand = use_imm ? imm_ext : reg_op;
    end

endmodule

// File: rtl/mulstep_core.sv
module mulstep_core
    import mulstep_pkg::*;
#(
    parameter int WLEN = 32
) (
    input  logic [WLEN-1:0] partial,
    input  logic [WLEN-1:0] mcand,
    input  logic            y_lsb,
    input  logic            n_in,
    input  logic            v_in,
    output logic [WLEN-1:0] sum,
    output msu_cc_t         cc,
    output logic            drop_bit
);
    localparam int MSB = WLEN - 1;

    logic [WLEN-1:0] shifted;
    logic [WLEN-1:0] addend;
    logic [WLEN:0]   wide;

    always_comb begin
        shifted  = {n_in ^ v_in, partial[MSB:1]};
        addend   = y_lsb ? mcand : '0;
        wide     = {1'b0, shifted} + {1'b0, addend};
        sum      = wide[MSB:0];
        drop_bit = partial[0];
        cc.n     = wide[MSB];
        cc.z     = (wide[MSB:0] == '0);
        cc.v     = (shifted[MSB] == addend[MSB]) && (wide[MSB] != shifted[MSB]);
        cc.c     = wide[WLEN];
    end

endmodule

// File: rtl/mulstep_state.sv
module mulstep_state
    import mulstep_pkg::*;
#(
    parameter int WLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_en,
    input  logic            load_en,
    input  logic [WLEN-1:0] load_y,
    input  msu_cc_t         load_cc,
    input  logic            fill_bit,
    input  msu_cc_t         step_cc,
    output logic [WLEN-1:0] y_q,
    output msu_cc_t         cc_q
);
    localparam int MSB = WLEN - 1;

    msu_act_e act;

    // Action selection: load has priority over step
    always_comb begin
        if (load_en) begin
            act = ACT_LOAD;
        end else if (step_en) begin
            act = ACT_STEP;
        end else begin
            act = ACT_HOLD;
        end
    end

    // Register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_q  <= '0;
            cc_q <= '0;
        end else begin
            unique case (act)
                ACT_LOAD: begin
                    y_q  <= load_y;
                    cc_q <= load_cc;
                end
                ACT_STEP: begin
                    y_q  <= {fill_bit, y_q[MSB:1]};
                    cc_q <= step_cc;
                end
                default: begin
                    y_q  <= y_q;
                    cc_q <= cc_q;
                end
            endcase
        end
    end

endmodule

// File: rtl/mulstep_unit.sv
module mulstep_unit
    import mulstep_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int WLEN = 32,
    parameter int IMMW = 13
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_en,
    input  logic            load_en,
    input  logic [WLEN-1:0] load_y,
    input  logic [3:0]      load_nzvc,
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] rs2_val,
    input  logic [IMMW-1:0] imm13,
    input  logic            use_imm,
    output logic [XLEN-1:0] rd_val,
    output logic [WLEN-1:0] y_q,
    output logic [3:0]      nzvc_q
);
    localparam int UPW = XLEN - WLEN;

    logic [WLEN-1:0] mcand;
    logic [WLEN-1:0] sum;
    msu_cc_t         step_cc;
    msu_cc_t         cc_q;
    logic            fill_bit;
    logic            unused_hi;

    assign unused_hi = ^{rs1_val[XLEN-1:WLEN], rs2_val[XLEN-1:WLEN]};

    mulstep_opsel #(.WLEN(WLEN), .IMMW(IMMW)) u_opsel (
        .reg_op  (rs2_val[WLEN-1:0]),
        .imm     (imm13),
        .use_imm (use_imm),
        .mcand   (mcand)
    );

    mulstep_core #(.WLEN(WLEN)) u_core (
        .partial  (rs1_val[WLEN-1:0]),
        .mcand    (mcand),
        .y_lsb    (y_q[0]),
        .n_in     (cc_q.n),
        .v_in     (cc_q.v),
        .sum      (sum),
        .cc       (step_cc),
        .drop_bit (fill_bit)
    );

    mulstep_state #(.WLEN(WLEN)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_en  (step_en),
        .load_en  (load_en),
        .load_y   (load_y),
        .load_cc  (msu_cc_t'(load_nzvc)),
        .fill_bit (fill_bit),
        .step_cc  (step_cc),
        .y_q      (y_q),
        .cc_q     (cc_q)
    );

    // Output process
    always_comb begin
        rd_val = {{UPW{1'b0}}, sum};
        nzvc_q = cc_q;
    end

endmodule

// File: rtl/mulstep_unit_chk.sv
module mulstep_unit_chk #(
    parameter int XLEN = 64,
    parameter int WLEN = 32,
    parameter int IMMW = 13
) (
    input logic            clk,
    input logic            rst_n,
    input logic            step_en,
    input logic            load_en,
    input logic [WLEN-1:0] load_y,
    input logic [3:0]      load_nzvc,
    input logic [XLEN-1:0] rs1_val,
    input logic [XLEN-1:0] rs2_val,
    input logic [IMMW-1:0] imm13,
    input logic            use_imm,
    input logic [XLEN-1:0] rd_val,
    input logic [WLEN-1:0] y_q,
    input logic [3:0]      nzvc_q
);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_en && !load_en) |=> ($stable(y_q) && $stable(nzvc_q)));

    p_yshift_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en) |=> (y_q == {$past(rs1_val[0]), $past(y_q[WLEN-1:1])}));

    p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> ((y_q == $past(load_y)) && (nzvc_q == $past(load_nzvc))));

    p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !y_q[0] |-> (rd_val[WLEN-1:0] == {nzvc_q[3] ^ nzvc_q[1], rs1_val[WLEN-1:1]}));

    p_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_val[XLEN-1:WLEN] == '0);

    p_zflag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en) |=> (nzvc_q[2] == ($past(rd_val[WLEN-1:0]) == '0)));

    p_nflag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !load_en) |=> (nzvc_q[3] == $past(rd_val[WLEN-1])));

endmodule

bind mulstep_unit mulstep_unit_chk #(.XLEN(XLEN), .WLEN(WLEN), .IMMW(IMMW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_en   (step_en),
    .load_en   (load_en),
    .load_y    (load_y),
    .load_nzvc (load_nzvc),
    .rs1_val   (rs1_val),
    .rs2_val   (rs2_val),
    .imm13     (imm13),
    .use_imm   (use_imm),
    .rd_val    (rd_val),
    .y_q       (y_q),
    .nzvc_q    (nzvc_q)
);

// File: tb/tb_mulstep_unit.sv
module tb_mulstep_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 5;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        step_en;
    logic        load_en;
    logic [31:0] load_y;
    logic [3:0]  load_nzvc;
    logic [63:0] rs1_val;
    logic [63:0] rs2_val;
    logic [12:0] imm13;
    logic        use_imm;
    logic [63:0] rd_val;
    logic [31:0] y_q;
    logic [3:0]  nzvc_q;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mulstep_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_en   (step_en),
        .load_en   (load_en),
        .load_y    (load_y),
        .load_nzvc (load_nzvc),
        .rs1_val   (rs1_val),
        .rs2_val   (rs2_val),
        .imm13     (imm13),
        .use_imm   (use_imm),
        .rd_val    (rd_val),
        .y_q       (y_q),
        .nzvc_q    (nzvc_q)
    );

    // Single-step vectors: stimulus, preset state, expected results
    localparam logic [63:0] V_RS1 [NV] = '{64'hFFFF_FFFF_0000_0003, 64'h10, 64'h2,
                                           64'hFFFF_FFFE, 64'h7FFF_FFFF};
    localparam logic [63:0] V_RS2 [NV] = '{64'hABCD_0000_0000_0005, 64'hFFFF_FFFF, 64'h1234,
                                           64'h8000_0000, 64'h0};
    localparam logic        V_IMS [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
    localparam logic [12:0] V_IMM [NV] = '{13'h0, 13'h0, 13'h1FFF, 13'h0, 13'h0FFF};
    localparam logic [31:0] V_Y   [NV] = '{32'h1, 32'h2, 32'h1, 32'h3, 32'h8000_0001};
    localparam logic [3:0]  V_CC  [NV] = '{4'b0000, 4'b1000, 4'b0000, 4'b0010, 4'b1010};
    localparam logic [31:0] E_RD  [NV] = '{32'h6, 32'h8000_0008, 32'h0, 32'h7FFF_FFFF,
                                           32'h4000_0FFE};
    localparam logic [31:0] E_Y   [NV] = '{32'h8000_0000, 32'h1, 32'h0, 32'h1, 32'hC000_0000};
    localparam logic [3:0]  E_CC  [NV] = '{4'b0000, 4'b1000, 4'b0101, 4'b0011, 4'b0000};

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [31:0] y, input logic [3:0] cc);
        load_en   = 1'b1;
        load_y    = y;
        load_nzvc = cc;
        @(negedge clk);
        load_en   = 1'b0;
    endtask

    task automatic run_product(input logic [31:0] mc, input logic [31:0] mp);
        logic [31:0] part;
        logic [31:0] hi;
        longint      exp_p;
        do_load(mp, 4'b0000);
        part = '0;
        for (int k = 0; k < 32; k++) begin
            rs1_val = {32'h0, part};
            rs2_val = {32'h0, mc};
            use_imm = 1'b0;
            step_en = 1'b1;
            #1;
            part = rd_val[31:0];
            @(negedge clk);
        end
        rs1_val = {32'h0, part};
        use_imm = 1'b1;
        imm13   = '0;
        #1;
        hi = rd_val[31:0];
        @(negedge clk);
        step_en = 1'b0;
        use_imm = 1'b0;
        exp_p = longint'($signed(mc)) * longint'({32'h0, mp});
        chk("R10 product", {hi, y_q}, exp_p);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++;
        bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n     = 1'b0;
        step_en   = 1'b0;
        load_en   = 1'b0;
        load_y    = '0;
        load_nzvc = '0;
        rs1_val   = '0;
        rs2_val   = '0;
        imm13     = '0;
        use_imm   = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset Y", {32'h0, y_q}, 64'h0);
        chk("R1 reset flags", {60'h0, nzvc_q}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table walk (R2..R7)
        for (int i = 0; i < NV; i++) begin
            do_load(V_Y[i], V_CC[i]);
            rs1_val = V_RS1[i];
            rs2_val = V_RS2[i];
            use_imm = V_IMS[i];
            imm13   = V_IMM[i];
            step_en = 1'b1;
            #1;
            chk("R2 R3 R4 rd low word", {32'h0, rd_val[31:0]}, {32'h0, E_RD[i]});
            chk("R5 rd upper zero", {32'h0, rd_val[63:32]}, 64'h0);
            @(negedge clk);
            step_en = 1'b0;
            chk("R7 Y shift", {32'h0, y_q}, {32'h0, E_Y[i]});
            chk("R6 flags", {60'h0, nzvc_q}, {60'h0, E_CC[i]});
        end

        // R8: hold with varying operands
        do_load(32'hA5A5_0F0F, 4'b1111);
        for (int j = 0; j < 4; j++) begin
            rs1_val = 64'h1357_9BDF_0000_0001 + 64'(j);
            rs2_val = 64'(j * 7);
            @(negedge clk);
        end
        chk("R8 hold Y", {32'h0, y_q}, 64'hA5A5_0F0F);
        chk("R8 hold flags", {60'h0, nzvc_q}, 64'hF);

        // R9: load and step in the same cycle
        rs1_val   = 64'h1;
        rs2_val   = 64'h3;
        step_en   = 1'b1;
        load_en   = 1'b1;
        load_y    = 32'h1234_5678;
        load_nzvc = 4'b0101;
        @(negedge clk);
        step_en = 1'b0;
        load_en = 1'b0;
        chk("R9 load wins Y", {32'h0, y_q}, 64'h1234_5678);
        chk("R9 load wins flags", {60'h0, nzvc_q}, 64'h5);

        // R10: full multiplication sequences
        run_product(32'd7, 32'd6);
        run_product(32'hFFFF_FFFD, 32'd5);
        run_product(32'h7FFF_FFFF, 32'hFFFF_FFFF);
        run_product(32'h8000_0000, 32'hFFFF_FFFF);
        run_product(32'h0001_2345, 32'h8000_0001);

        // R1: reset in mid-run clears state
        do_load(32'hFFFF_FFFF, 4'b1111);
        rst_n = 1'b0;
        #1;
        chk("R1 async reset Y", {32'h0, y_q}, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule